// File: doc/BRIEF.md
# Sprite and Background Priority Compositor

This block merges one pixel from each of a set of hardware sprites with one background layer. It produces a single colour index for each screen position. For every sprite it takes a presence flag, a colour index and a behind-background bit. For the background it takes a foreground-pixel flag with its colour, plus a fill colour used where that foreground pixel is clear.

The sprites form a fixed stack in which a lower index is nearer the viewer. The stack is resolved first: the lowest-indexed sprite present at the pixel is the only sprite that can be seen there. Only that front-most sprite's behind bit then decides whether the sprite layer or the background foreground pixel wins. Behind bits on sprites deeper in the stack have no effect, and no behind bit changes the order of the sprites.

As a result, a rear sprite set to sit in front of the background stays hidden under a nearer sprite set to sit behind it. Where that nearer sprite overlaps background foreground pixels, the background shows through. The result is registered with one cycle of latency, and a valid flag travels with it.

Top module: `spr_bg_compositor`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `out_valid` is 0 and `out_color` is 0.
- R2: A pixel presented with `in_valid` high at clock edge N appears on `out_color` with `out_valid` high after edge N. When `in_valid` is low at an edge, `out_valid` is low after it.
- R3: While `in_valid` is low, `out_color` holds its previous value, whatever the other inputs do.
- R4: With no bit of `spr_on` set, the output is `bg_fg_color` if `bg_fg_on` is 1 and `bg_fill_color` otherwise.
- R5: Sprite i is present when `spr_on[i]` is 1, and its colour is `spr_color[i*CW +: CW]`. Among present sprites, the one with the lowest index supplies the sprite colour.
- R6: If the front-most present sprite has its `spr_behind` bit at 0, its colour is output even where `bg_fg_on` is 1.
- R7: If the front-most present sprite has its `spr_behind` bit at 1, the output is `bg_fg_color` where `bg_fg_on` is 1. Where `bg_fg_on` is 0, the output is that sprite's colour.
- R8: The `spr_behind` bits of sprites behind the front-most present sprite have no effect on the output. A rear sprite with its bit at 0 stays hidden under a front sprite whose bit is 1.
- R9: A sprite's `spr_behind` bit never changes its order among the sprites. A front sprite with its bit at 1 still covers a rear sprite with its bit at 0 where `bg_fg_on` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel is valid this cycle |
| spr_on | input | NSPR | Per-sprite pixel-present flags, bit i for sprite i |
| spr_color | input | NSPR*CW | Per-sprite colour indices, sprite i in bits i*CW +: CW |
| spr_behind | input | NSPR | Per-sprite behind-background bits |
| bg_fg_on | input | 1 | Background foreground pixel is set |
| bg_fg_color | input | CW | Background foreground colour |
| bg_fill_color | input | CW | Background fill colour |
| out_valid | output | 1 | Output pixel is valid |
| out_color | output | CW | Composited colour index |

## Verification
The bench builds the block with its defaults: eight sprites and 4-bit colours. Because each sprite's colour equals its index plus one, the output reveals which sprite won. These values reach the full stack depth, so the rearmost sprite, the all-present case and the paradox cases are all exercised. In the paradox cases a nearer behind-marked sprite hides a farther front-marked one, both over set background pixels and over clear ones.

// File: rtl/spr_comp_pkg.sv
package spr_comp_pkg;
  typedef enum logic [1:0] {
    SRC_FILL   = 2'd0,
    SRC_BGFG   = 2'd1,
    SRC_SPRITE = 2'd2
  } layer_src_e;
endpackage

// File: rtl/spr_front_pick.sv
module spr_front_pick #(
  parameter int NSPR = 8,
  parameter int CW   = 4
) (
  input  logic [NSPR-1:0]    spr_on,
  input  logic [NSPR*CW-1:0] spr_color,
  input  logic [NSPR-1:0]    spr_behind,
  output logic               hit,
  output logic [CW-1:0]      front_color,
  output logic               front_behind
);
  logic [CW-1:0] col_arr [NSPR];

  genvar g;
  generate
    for (g = 0; g < NSPR; g++) begin : g_unpack
      assign col_arr[g] = spr_color[g*CW +: CW];
    end
  endgenerate

  // Walk from the back of the stack forward, so the lowest index present wins.
  always_comb begin
    hit          = 1'b0;
    front_color  = '0;
    front_behind = 1'b0;
    for (int i = NSPR-1; i >= 0; i--) begin
      if (spr_on[i]) begin
        hit          = 1'b1;
        front_color  = col_arr[i];
        front_behind = spr_behind[i];
      end
    end
  end
endmodule

// File: rtl/spr_layer_mux.sv
module spr_layer_mux
  import spr_comp_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          hit,
  input  logic [CW-1:0] front_color,
  input  logic          front_behind,
  input  logic          bg_fg_on,
  input  logic [CW-1:0] bg_fg_color,
  input  logic [CW-1:0] bg_fill_color,
  output logic [CW-1:0] pix_color
);
  layer_src_e src;

  always_comb begin
    if (hit && (!front_behind || !bg_fg_on)) src = SRC_SPRITE;
    else if (bg_fg_on)                      src = SRC_BGFG;
    else                                    src = SRC_FILL;
  end

  always_comb begin
    unique case (src)
      SRC_SPRITE: pix_color = front_color;
      SRC_BGFG:   pix_color = bg_fg_color;
      default:    pix_color = bg_fill_color;
    endcase
  end
endmodule

// File: rtl/spr_bg_compositor.sv
module spr_bg_compositor #(
  parameter int NSPR = 8,
  parameter int CW   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [NSPR-1:0]    spr_on,
  input  logic [NSPR*CW-1:0] spr_color,
  input  logic [NSPR-1:0]    spr_behind,
  input  logic               bg_fg_on,
  input  logic [CW-1:0]      bg_fg_color,
  input  logic [CW-1:0]      bg_fill_color,
  output logic               out_valid,
  output logic [CW-1:0]      out_color
);
  localparam int SPR_BUS_W = NSPR * CW;

  logic          hit;
  logic [CW-1:0] front_color;
  logic          front_behind;
  logic [CW-1:0] pix_color;

  spr_front_pick #(.NSPR(NSPR), .CW(CW)) u_pick (
    .spr_on       (spr_on),
    .spr_color    (spr_color[SPR_BUS_W-1:0]),
    .spr_behind   (spr_behind),
    .hit          (hit),
    .front_color  (front_color),
    .front_behind (front_behind)
  );

  spr_layer_mux #(.CW(CW)) u_mux (
    .hit           (hit),
    .front_color   (front_color),
    .front_behind  (front_behind),
    .bg_fg_on      (bg_fg_on),
    .bg_fg_color   (bg_fg_color),
    .bg_fill_color (bg_fill_color),
    .pix_color     (pix_color)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_color <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_color <= pix_color;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3
  hold_color_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_color));

  // R4
  fill_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && spr_on == '0 && !bg_fg_on) |=> out_color == $past(bg_fill_color));

  // R6
  front_sprite_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && spr_on[0] && !spr_behind[0]) |=> out_color == $past(spr_color[CW-1:0]));

  // R7
  behind_shows_bg_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && spr_on[0] && spr_behind[0] && bg_fg_on) |=> out_color == $past(bg_fg_color));
endmodule

// File: tb/tb_spr_bg_compositor.sv
module tb_spr_bg_compositor;
  localparam int NSPR = 8;
  localparam int CW   = 4;

  logic               clk = 1'b0;
  logic               rst;
  logic               in_valid;
  logic [NSPR-1:0]    spr_on;
  logic [NSPR*CW-1:0] spr_color;
  logic [NSPR-1:0]    spr_behind;
  logic               bg_fg_on;
  logic [CW-1:0]      bg_fg_color;
  logic [CW-1:0]      bg_fill_color;
  logic               out_valid;
  logic [CW-1:0]      out_color;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  spr_bg_compositor #(.NSPR(NSPR), .CW(CW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .spr_on(spr_on),
    .spr_color(spr_color), .spr_behind(spr_behind), .bg_fg_on(bg_fg_on),
    .bg_fg_color(bg_fg_color), .bg_fill_color(bg_fill_color),
    .out_valid(out_valid), .out_color(out_color)
  );

  typedef struct packed {
    logic [7:0] on;
    logic [7:0] beh;
    logic       fg;
    logic [3:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NVEC = 12;
  // Sprite i colour is i+1, background foreground colour A, fill colour C.
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 8'h00, 1'b0, 4'hC, 8'd4},  // R4 empty, fill
    '{8'h00, 8'h00, 1'b1, 4'hA, 8'd4},  // R4 empty, fg pixel
    '{8'h01, 8'h00, 1'b1, 4'h1, 8'd6},  // R6 front-mode sprite over fg
    '{8'h06, 8'h00, 1'b0, 4'h2, 8'd5},  // R5 lowest index wins
    '{8'h80, 8'h00, 1'b0, 4'h8, 8'd5},  // R5 rearmost alone
    '{8'hFF, 8'h00, 1'b1, 4'h1, 8'd5},  // R5 all present
    '{8'h04, 8'h04, 1'b1, 4'hA, 8'd7},  // R7 behind over fg
    '{8'h04, 8'h04, 1'b0, 4'h3, 8'd7},  // R7 behind over clear bg
    '{8'h03, 8'h01, 1'b1, 4'hA, 8'd8},  // R8 rear front-mode sprite hidden
    '{8'h03, 8'h01, 1'b0, 4'h1, 8'd9},  // R9 order unchanged by bit
    '{8'h30, 8'h20, 1'b1, 4'h5, 8'd8},  // R8 rear behind bit ignored
    '{8'hC0, 8'h80, 1'b1, 4'h7, 8'd9}   // R9 sprite 6 still in front of 7
  };

  task automatic check(input logic [CW-1:0] act, input logic [CW-1:0] exp,
                       input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] on, input logic [7:0] beh,
                       input logic fg);
    @(negedge clk);
    in_valid   = v;
    spr_on     = on;
    spr_behind = beh;
    bg_fg_on   = fg;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b1;
    spr_on = 8'hFF;
    spr_behind = 8'h00;
    spr_color = 32'h8765_4321;
    bg_fg_on = 1'b1;
    bg_fg_color = 4'hA;
    bg_fill_color = 4'hC;
    repeat (3) @(posedge clk);
    #1;
    // R1
    check({3'b0, out_valid}, 4'h0, "R1 valid");
    check(out_color, 4'h0, "R1 color");
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      drive(1'b1, VECS[k].on, VECS[k].beh, VECS[k].fg);
      @(posedge clk);
      #1;
      check(out_color, VECS[k].exp, $sformatf("R%0d vec%0d", VECS[k].req, k));
    end

    // R2: one-cycle latency and valid alignment
    drive(1'b1, 8'h40, 8'h00, 1'b0);
    @(posedge clk);
    #1;
    check({3'b0, out_valid}, 4'h1, "R2 valid high");
    check(out_color, 4'h7, "R2 color after one edge");
    drive(1'b0, 8'h00, 8'h00, 1'b0);
    @(posedge clk);
    #1;
    check({3'b0, out_valid}, 4'h0, "R2 valid low");

    // R3: colour held while not valid, despite changing inputs
    check(out_color, 4'h7, "R3 hold");
    drive(1'b0, 8'h01, 8'h00, 1'b1);
    bg_fill_color = 4'h3;
    @(posedge clk);
    #1;
    check(out_color, 4'h7, "R3 hold changed inputs");

    // R4 with a different fill value
    drive(1'b1, 8'h00, 8'hFF, 1'b0);
    @(posedge clk);
    #1;
    check(out_color, 4'h3, "R4 new fill");

    // R1: reset clears a held value
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(out_color, 4'h0, "R1 reset again");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule